// File: doc/BRIEF.md
# Load/Store Byte-Lane and Alignment Unit

This unit sits between a 32-bit integer datapath and a word-addressed, little-endian data memory port. For a store it takes the byte address, the source register value and the access size, and presents a word address, the write data placed on the correct byte lanes and a matching byte-enable mask. Only the low byte (byte store) or the low halfword (halfword store) of the source register ever reaches memory.

For a load it issues the word read and, when the memory answers one cycle later, picks the addressed byte or halfword out of the returned word and widens it to 32 bits. The widening is signed by default and unsigned when the request asks for it. The lane offset, size and signedness of the load are held in a small response register so that a new request may be presented while the data of the previous load returns.

Every halfword or word request whose address is not a multiple of its size is refused in the same cycle. No memory request is issued, an error flag rises together with cause code 4, and the offending byte address is presented so that a bad-address register outside the unit can capture it. Byte requests are always accepted.

Top module: `lsu_lane_unit`

## Requirements
- R1: An accepted request raises memReq in the same cycle, with memWrite equal to reqWrite and memAddr equal to reqAddr with bits [1:0] cleared.
- R2: An aligned byte store (reqSize 0) drives a one-hot memBe with bit reqAddr[1:0] set, and places storeData[7:0] on that lane of memWdata; all other lanes are zero.
- R3: A halfword store (reqSize 1) with reqAddr[0]=0 drives memBe 4'b0011 when reqAddr[1]=0 and 4'b1100 when reqAddr[1]=1, with storeData[15:0] on those lanes and zero elsewhere.
- R4: A word store (reqSize 2, and reqSize 3 is treated the same) with reqAddr[1:0]=0 drives memBe 4'b1111 and memWdata equal to storeData.
- R5: A halfword request with reqAddr[0]=1, or a word request with reqAddr[1:0] not zero, raises addrErr in the same cycle with errCause 4 and badAddr equal to reqAddr. In that cycle memReq is low, memBe and memWdata are zero, and no loadValid follows in the next cycle.
- R6: A byte request is never flagged as misaligned, whatever reqAddr[1:0] holds.
- R7: An accepted load raises loadValid exactly one cycle later, and loadData is then formed from memRdata of that cycle. A load request drives memBe and memWdata to zero.
- R8: A byte load returns the byte on lane reqAddr[1:0]: sign-extended when reqUnsigned is 0 and zero-extended when it is 1.
- R9: A halfword load returns bytes reqAddr[1:0] and reqAddr[1:0]+1 (low byte first): sign-extended when reqUnsigned is 0 and zero-extended when it is 1.
- R10: A word load returns memRdata unchanged, whatever reqUnsigned holds.
- R11: When addrErr is low, errCause and badAddr are zero; when loadValid is low, loadData is zero.
- R12: While rstN is low, loadValid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqUnsigned | input | 1 | Zero-extend a byte or halfword load |
| reqAddr | input | 32 | Byte address of the access |
| storeData | input | 32 | Source register value for a store |
| memReq | output | 1 | Memory access issued this cycle |
| memWrite | output | 1 | Issued access is a write |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Lane-placed write data |
| memBe | output | 4 | Byte enables of the write |
| memRdata | input | 32 | Read word, valid the cycle after a load issue |
| loadValid | output | 1 | loadData holds a load result |
| loadData | output | 32 | Extended load result |
| addrErr | output | 1 | Misaligned request refused |
| errCause | output | 5 | Exception cause code (4 on misalignment) |
| badAddr | output | 32 | Faulting byte address |

## Verification
Two functions share a cycle when a load's data returns through the response register while a fresh request is being judged for alignment. The bench provokes this by issuing an aligned load and, in the very next cycle, presenting a misaligned word store alongside the returning memory word; it then expects the extended load result and the refused store flags at once. Beyond that, every size, lane, signedness and direction is swept against several data patterns and two address regions, with expected lanes, masks and extensions computed arithmetically.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int DATA_W     = WORD_BYTES * 8;
  localparam int CAUSE_W    = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic              storeFire;
    logic              loadFire;
    logic              misaligned;
    logic [LANE_W-1:0] reqLane;
    logic [LANE_W-1:0] reqLast;
    accSize_e          reqSize;
    logic              rspValid;
    logic [LANE_W-1:0] rspLane;
    accSize_e          rspSize;
    logic              rspUnsigned;
  } laneCtrl_t;
endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  accSize_e          reqSize,
  input  logic              reqUnsigned,
  input  logic [LANE_W-1:0] lowAddr,
  output laneCtrl_t         ctrl
);
  logic [LANE_W-1:0] spanMask;
  logic              misaligned;
  logic              rspValidQ;
  logic [LANE_W-1:0] rspLaneQ;
  accSize_e          rspSizeQ;
  logic              rspUnsignedQ;

  always_comb begin
    unique case (reqSize)
      SZ_BYTE: spanMask = '0;
      SZ_HALF: spanMask = LANE_W'(1);
      default: spanMask = '1;
    endcase
  end

  assign misaligned = reqValid && ((lowAddr & spanMask) != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValidQ    <= 1'b0;
      rspLaneQ     <= '0;
      rspSizeQ     <= SZ_BYTE;
      rspUnsignedQ <= 1'b0;
    end else begin
      rspValidQ <= reqValid && !reqWrite && !misaligned;
      if (reqValid && !reqWrite && !misaligned) begin
        rspLaneQ     <= lowAddr;
        rspSizeQ     <= reqSize;
        rspUnsignedQ <= reqUnsigned;
      end
    end
  end

  always_comb begin
    ctrl.storeFire   = reqValid && reqWrite && !misaligned;
    ctrl.loadFire    = reqValid && !reqWrite && !misaligned;
    ctrl.misaligned  = misaligned;
    ctrl.reqLane     = lowAddr;
    ctrl.reqLast     = lowAddr | spanMask;
    ctrl.reqSize     = reqSize;
    ctrl.rspValid    = rspValidQ;
    ctrl.rspLane     = rspLaneQ;
    ctrl.rspSize     = rspSizeQ;
    ctrl.rspUnsigned = rspUnsignedQ;
  end
endmodule

// File: rtl/lsu_lane_datapath.sv
module lsu_lane_datapath
  import lsu_lane_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int unsigned CAUSE_CODE = 4
) (
  input  laneCtrl_t          ctrl,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  storeData,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [WORD_BYTES-1:0] memBe,
  output logic [DATA_W-1:0]  loadData,
  output logic [CAUSE_W-1:0] errCause,
  output logic [ADDR_W-1:0]  badAddr
);
  localparam int SHIFT_W = LANE_W + 3;

  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] rdShifted;
  logic [SHIFT_W-1:0] wrShift;
  logic [SHIFT_W-1:0] rdShift;

  assign memAddr = {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  // store side
  always_comb begin
    unique case (ctrl.reqSize)
      SZ_BYTE: sizeMask = DATA_W'(8'hFF);
      SZ_HALF: sizeMask = DATA_W'(16'hFFFF);
      default: sizeMask = '1;
    endcase
  end

  assign wrShift  = {ctrl.reqLane, 3'b000};
  assign memWdata = ctrl.storeFire ? ((storeData & sizeMask) << wrShift) : '0;

  for (genvar lane = 0; lane < WORD_BYTES; lane++) begin : g_laneEn
    assign memBe[lane] = ctrl.storeFire &&
                         (LANE_W'(lane) >= ctrl.reqLane) &&
                         (LANE_W'(lane) <= ctrl.reqLast);
  end

  // load side
  assign rdShift   = {ctrl.rspLane, 3'b000};
  assign rdShifted = memRdata >> rdShift;

  always_comb begin
    loadData = '0;
    if (ctrl.rspValid) begin
      unique case (ctrl.rspSize)
        SZ_BYTE: loadData = {{(DATA_W-8){!ctrl.rspUnsigned && rdShifted[7]}},
                             rdShifted[7:0]};
        SZ_HALF: loadData = {{(DATA_W-16){!ctrl.rspUnsigned && rdShifted[15]}},
                             rdShifted[15:0]};
        default: loadData = memRdata;
      endcase
    end
  end

  // fault reporting
  assign errCause = ctrl.misaligned ? CAUSE_W'(CAUSE_CODE) : '0;
  assign badAddr  = ctrl.misaligned ? reqAddr : '0;
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int unsigned CAUSE_CODE = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [1:0]            reqSize,
  input  logic                  reqUnsigned,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     storeData,
  output logic                  memReq,
  output logic                  memWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic [WORD_BYTES-1:0] memBe,
  input  logic [DATA_W-1:0]     memRdata,
  output logic                  loadValid,
  output logic [DATA_W-1:0]     loadData,
  output logic                  addrErr,
  output logic [CAUSE_W-1:0]    errCause,
  output logic [ADDR_W-1:0]     badAddr
);
  laneCtrl_t ctrl;

  lsu_lane_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (accSize_e'(reqSize)),
    .reqUnsigned(reqUnsigned),
    .lowAddr    (reqAddr[LANE_W-1:0]),
    .ctrl       (ctrl)
  );

  lsu_lane_datapath #(
    .ADDR_W    (ADDR_W),
    .CAUSE_CODE(CAUSE_CODE)
  ) i_datapath (
    .ctrl     (ctrl),
    .reqAddr  (reqAddr),
    .storeData(storeData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memBe    (memBe),
    .loadData (loadData),
    .errCause (errCause),
    .badAddr  (badAddr)
  );

  assign memReq    = ctrl.storeFire || ctrl.loadFire;
  assign memWrite  = ctrl.storeFire;
  assign loadValid = ctrl.rspValid;
  assign addrErr   = ctrl.misaligned;
endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memReq,
  input logic              memWrite,
  input logic [3:0]        memBe,
  input logic [31:0]       memWdata,
  input logic              loadValid,
  input logic [31:0]       loadData,
  input logic              addrErr,
  input logic [4:0]        errCause,
  input logic [ADDR_W-1:0] badAddr
);
  assert_err_blocks_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (!memReq && memBe == 4'b0 && memWdata == 32'b0));

  assert_err_report_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (errCause == 5'd4 && badAddr == reqAddr));

  assert_no_rsp_after_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> !loadValid);

  assert_byte_always_ok_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0) |-> (!addrErr && memReq));

  assert_byte_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && reqSize == 2'd0) |-> ($countones(memBe) == 1));

  assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && reqSize[1]) |-> (memBe == 4'hF));

  assert_load_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |=> loadValid);

  assert_rsp_has_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memReq && !memWrite));

  assert_quiet_when_ok_R11: assert property (@(posedge clk) disable iff (!rstN)
    !addrErr |-> (errCause == 5'd0 && badAddr == '0));

  assert_quiet_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (loadData == 32'b0));

  assert_store_not_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> !(memReq && !memWrite));
endmodule

bind lsu_lane_unit lsu_lane_checker #(.ADDR_W(ADDR_W)) i_lsu_lane_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqSize  (reqSize),
  .reqAddr  (reqAddr),
  .memReq   (memReq),
  .memWrite (memWrite),
  .memBe    (memBe),
  .memWdata (memWdata),
  .loadValid(loadValid),
  .loadData (loadData),
  .addrErr  (addrErr),
  .errCause (errCause),
  .badAddr  (badAddr)
);

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqUnsigned = 1'b0;
  logic [31:0] reqAddr = 32'h0;
  logic [31:0] storeData = 32'h0;
  logic        memReq;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = 32'h0;
  logic        loadValid;
  logic [31:0] loadData;
  logic        addrErr;
  logic [4:0]  errCause;
  logic [31:0] badAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .reqAddr(reqAddr),
    .storeData(storeData), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .memRdata(memRdata), .loadValid(loadValid), .loadData(loadData),
    .addrErr(addrErr), .errCause(errCause), .badAddr(badAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int sizeBytes(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] extend(input logic [31:0] word, input int lane,
                                         input int s, input bit uns);
    logic [31:0] sh;
    sh = word >> (8 * lane);
    if (s == 0) return uns ? {24'b0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
    if (s == 1) return uns ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    return word;
  endfunction

  task automatic judgeRequest(input logic [31:0] addr, input int s,
                              input bit wr, input logic [31:0] sd);
    int n;
    bit mis;
    logic [3:0] beExp;
    logic [63:0] wExp;
    n = sizeBytes(s);
    mis = (addr % n) != 0;
    beExp = (mis || !wr) ? 4'b0 : 4'(((1 << n) - 1) << addr[1:0]);
    wExp = (mis || !wr) ? 64'b0 :
           ((64'(sd) & ((64'd1 << (8 * n)) - 1)) << (8 * addr[1:0]));
    check(memReq == !mis, mis ? "R5 memReq" : "R1 memReq", 32'(memReq), 32'(!mis));
    check(addrErr == mis, s == 0 ? "R6 addrErr" : "R5 addrErr", 32'(addrErr), 32'(mis));
    if (mis) begin
      check(errCause == 5'd4, "R5 errCause", 32'(errCause), 32'd4);
      check(badAddr == addr, "R5 badAddr", badAddr, addr);
    end else begin
      check(errCause == 5'd0 && badAddr == 32'b0, "R11 quiet error", badAddr, 32'b0);
      check(memWrite == wr, "R1 memWrite", 32'(memWrite), 32'(wr));
      check(memAddr == {addr[31:2], 2'b00}, "R1 memAddr", memAddr, {addr[31:2], 2'b00});
    end
    check(memBe == beExp, wr ? (s == 0 ? "R2 memBe" : s == 1 ? "R3 memBe" : "R4 memBe")
                             : "R7 memBe", 32'(memBe), 32'(beExp));
    check(memWdata == wExp[31:0], wr ? (s == 0 ? "R2 memWdata" : s == 1 ? "R3 memWdata"
                                                : "R4 memWdata") : "R7 memWdata",
          memWdata, wExp[31:0]);
  endtask

  task automatic doAccess(input logic [31:0] addr, input int s, input bit wr,
                          input bit uns, input logic [31:0] sd, input logic [31:0] rd,
                          input int sizeCode);
    bit mis;
    logic [31:0] exp;
    mis = (addr % sizeBytes(s)) != 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = 2'(sizeCode); reqUnsigned = uns;
    reqAddr = addr; storeData = sd; memRdata = 32'h0;
    #1;
    judgeRequest(addr, s, wr, sd);
    @(posedge clk);
    #1;
    reqValid = 1'b0; memRdata = rd;
    #1;
    exp = (wr || mis) ? 32'b0 : extend(rd, int'(addr[1:0]), s, uns);
    check(loadValid == (!wr && !mis), mis ? "R5 no loadValid" : "R7 loadValid",
          32'(loadValid), 32'(!wr && !mis));
    check(loadData == exp, s == 0 ? "R8 loadData" : s == 1 ? "R9 loadData"
                                    : (wr || mis) ? "R11 loadData" : "R10 loadData",
          loadData, exp);
  endtask

  initial begin
    logic [31:0] patterns [4];
    logic [31:0] bases [2];
    patterns[0] = 32'h80FF7F01;
    patterns[1] = 32'h7F8001FE;
    patterns[2] = 32'hDEADBEEF;
    patterns[3] = 32'h12345678;
    bases[0] = 32'h10000040;
    bases[1] = 32'hFFFFFFF0;

    // R12: reset state
    repeat (2) @(posedge clk);
    #1;
    check(loadValid == 1'b0, "R12 loadValid in reset", 32'(loadValid), 32'b0);
    check(memReq == 1'b0 && addrErr == 1'b0, "R12 idle in reset", 32'(memReq), 32'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 4; s++)
        for (int lane = 0; lane < 4; lane++)
          for (int p = 0; p < 4; p++)
            for (int wu = 0; wu < 3; wu++)
              doAccess(bases[b] + 32'(lane), (s == 3) ? 2 : s, wu == 0, wu == 2,
                       patterns[p], patterns[3 - p], s);

    // coincidence: load data returns while a misaligned store is refused
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd1; reqUnsigned = 1'b0;
    reqAddr = 32'h00002002;
    @(posedge clk);
    #1;
    reqWrite = 1'b1; reqSize = 2'd2; reqAddr = 32'h00003001;
    storeData = 32'hCAFEF00D; memRdata = 32'h9ABC1234;
    #1;
    check(loadValid == 1'b1, "R7 loadValid beside refused store", 32'(loadValid), 32'd1);
    check(loadData == 32'hFFFF9ABC, "R9 loadData beside refused store",
          loadData, 32'hFFFF9ABC);
    check(addrErr == 1'b1 && errCause == 5'd4, "R5 refused beside load",
          32'(errCause), 32'd4);
    check(memBe == 4'b0 && !memReq, "R5 no write beside load", 32'(memBe), 32'b0);
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    #1;
    check(loadValid == 1'b0, "R5 no response after refused store", 32'(loadValid), 32'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule